// File: doc/BRIEF.md
# GPIO Port Pin Interrupt Unit

This block produces the interrupt for one 32-pin general-purpose I/O port. Every pin enters through a two-flop synchroniser clocked by the system clock. A 2-bit trigger code per pin sets what counts as an event: a rising edge, a falling edge, a high level or a low level. Events from qualified pins set bits in a status register. Software clears those bits by writing 1 to them. A mask register selects which status bits reach the single port interrupt output. That output is registered.

A pin is qualified when its use bit is 1 and its direction bit is 0, which makes it an input in interrupt service. The trigger codes are held in two 32-bit configuration words. The low word covers pins 0 to 15 and the high word covers pins 16 to 31. The field for a pin starts at bit 2·(pin mod 16). Software reads the status word and services the set bits starting from bit 0 and moving upward. It then clears each serviced bit.

Top module: `gpi_port`

## Requirements
- R1: After reset, every register (direction, use, both trigger words, mask, status) reads 0 and `irq_o` is 0.
- R2: Register word addresses are: direction 0, use 1, trigger low 2, trigger high 3, mask 4, status 5. The direction, use, trigger and mask registers read back the value last written.
- R3: Trigger code 2'b00 latches a rising edge. A pin change applied before clock edge N sets the status bit at edge N+2, and the bit is not yet set after edge N+1.
- R4: Trigger code 2'b01 latches a falling edge of the pin, with the same latency as R3.
- R5: Trigger code 2'b10 (high level) sets the status bit on every clock while the synchronised pin is 1. As a result, the bit sets again after a clear while the level persists.
- R6: Trigger code 2'b11 (low level) sets the status bit on every clock while the synchronised pin is 0.
- R7: A write to the status register clears the bits written as 1. Bits written as 0 are unchanged, and no other cause clears a status bit.
- R8: When a clear and a new event for the same pin fall in the same cycle, the status bit stays 1.
- R9: `irq_o` equals the OR over all pins of (status AND mask) as it stood one cycle earlier. A mask bit of 1 enables the pin.
- R10: A pin whose use bit is 0 or whose direction bit is 1 never sets its status bit.
- R11: Pin i takes its trigger code from bits [2·(i mod 16)+1 : 2·(i mod 16)] of the trigger low word for i < 16 and of the trigger high word for i ≥ 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word address for writes |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Register word address for reads |
| rd_data | output | 32 | Read data of `rd_addr` (combinational) |
| pin_i | input | 32 | Asynchronous pin levels |
| irq_o | output | 1 | Registered port interrupt |

## Verification
The assertions assume that `wr_en`, `wr_addr` and `wr_data` are stable around each clock edge and that a write lasts exactly one cycle. They do not assume that pins change synchronously: every event property is stated on the synchronised samples, never on `pin_i` itself. The bench drives every input at the falling clock edge, writes one register per cycle at most, and flips pins at random between edges. It also holds some pins steady long enough to reach the level triggers. The random mix includes clears that coincide with active levels, so the case where an event beats a clear in the same cycle is reached often.

// File: rtl/gpi_pkg.sv
package gpi_pkg;
    localparam int unsigned NPIN  = 32;
    localparam int unsigned DW    = 32;
    localparam int unsigned AW    = 3;
    localparam int unsigned TBITS = 2;

    typedef enum logic [TBITS-1:0] {
        TRG_RISE = 2'b00,
        TRG_FALL = 2'b01,
        TRG_HIGH = 2'b10,
        TRG_LOW  = 2'b11
    } trig_e;

    typedef enum logic [AW-1:0] {
        A_DIR   = 3'd0,
        A_USE   = 3'd1,
        A_TRGLO = 3'd2,
        A_TRGHI = 3'd3,
        A_MASK  = 3'd4,
        A_STAT  = 3'd5
    } addr_e;
endpackage

// File: rtl/gpi_sync.sv
module gpi_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prv_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] cur;
        logic [W-1:0] prv;
    } sy_t;

    sy_t sy_d, sy_q;

    always_comb begin
        sy_d      = sy_q;
        sy_d.meta = raw_i;
        sy_d.cur  = sy_q.meta;
        sy_d.prv  = sy_q.cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign cur_o = sy_q.cur;
    assign prv_o = sy_q.prv;
endmodule

// File: rtl/gpi_detect.sv
module gpi_detect
    import gpi_pkg::*;
#(
    parameter int unsigned N = 32
) (
    input  logic [N-1:0]       cur_i,
    input  logic [N-1:0]       prv_i,
    input  logic [TBITS*N-1:0] cfg_i,
    input  logic [N-1:0]       qual_i,
    output logic [N-1:0]       ev_o
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        logic  raw;
        trig_e code;
        assign code = trig_e'(cfg_i[TBITS*i +: TBITS]);
        always_comb begin
            unique case (code)
                TRG_RISE: raw = cur_i[i] & ~prv_i[i];
                TRG_FALL: raw = ~cur_i[i] & prv_i[i];
                TRG_HIGH: raw = cur_i[i];
                TRG_LOW:  raw = ~cur_i[i];
                default:  raw = 1'b0;
            endcase
        end
        assign ev_o[i] = raw & qual_i[i];
    end
endmodule

// File: rtl/gpi_port.sv
module gpi_port
    import gpi_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [DW-1:0]   rd_data,
    input  logic [NPIN-1:0] pin_i,
    output logic            irq_o
);
    localparam int unsigned CFGW = TBITS * NPIN;

    typedef struct packed {
        logic [NPIN-1:0] dir;
        logic [NPIN-1:0] use_en;
        logic [DW-1:0]   trlo;
        logic [DW-1:0]   trhi;
        logic [NPIN-1:0] mask;
        logic [NPIN-1:0] stat;
        logic            irq;
    } rg_t;

    rg_t rg_d, rg_q;

    logic [NPIN-1:0] cur_w, prv_w, qual_w, ev_w, clr_w;
    logic [NPIN-1:0] stat_q, mask_q;
    logic [CFGW-1:0] cfg_w;

    gpi_sync #(.W(NPIN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (pin_i),
        .cur_o (cur_w),
        .prv_o (prv_w)
    );

    assign cfg_w  = {rg_q.trhi, rg_q.trlo};
    assign qual_w = rg_q.use_en & ~rg_q.dir;

    gpi_detect #(.N(NPIN)) u_det (
        .cur_i  (cur_w),
        .prv_i  (prv_w),
        .cfg_i  (cfg_w),
        .qual_i (qual_w),
        .ev_o   (ev_w)
    );

    always_comb begin
        rg_d  = rg_q;
        clr_w = '0;
        if (wr_en) begin
            case (addr_e'(wr_addr))
                A_DIR:   rg_d.dir    = wr_data;
                A_USE:   rg_d.use_en = wr_data;
                A_TRGLO: rg_d.trlo   = wr_data;
                A_TRGHI: rg_d.trhi   = wr_data;
                A_MASK:  rg_d.mask   = wr_data;
                A_STAT:  clr_w       = wr_data;
                default: ;
            endcase
        end
        rg_d.stat = (rg_q.stat & ~clr_w) | ev_w;
        rg_d.irq  = |(rg_q.stat & rg_q.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        case (addr_e'(rd_addr))
            A_DIR:   rd_data = rg_q.dir;
            A_USE:   rd_data = rg_q.use_en;
            A_TRGLO: rd_data = rg_q.trlo;
            A_TRGHI: rd_data = rg_q.trhi;
            A_MASK:  rd_data = rg_q.mask;
            A_STAT:  rd_data = rg_q.stat;
            default: rd_data = '0;
        endcase
    end

    assign stat_q = rg_q.stat;
    assign mask_q = rg_q.mask;
    assign irq_o  = rg_q.irq;
endmodule

// File: rtl/gpi_chk.sv
module gpi_chk
    import gpi_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [AW-1:0]         wr_addr,
    input logic [DW-1:0]         wr_data,
    input logic [NPIN-1:0]       cur_w,
    input logic [NPIN-1:0]       prv_w,
    input logic [TBITS*NPIN-1:0] cfg_w,
    input logic [NPIN-1:0]       qual_w,
    input logic [NPIN-1:0]       stat_q,
    input logic [NPIN-1:0]       mask_q,
    input logic                  irq_o
);
    logic [NPIN-1:0] clr_c;
    assign clr_c = (wr_en && wr_addr == A_STAT) ? wr_data : '0;

    // R7: a status bit falls only when it was written as 1
    a_r7_only_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(stat_q) & ~stat_q & ~$past(clr_c)) == '0));

    // R9: interrupt output follows masked status one cycle later
    a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(stat_q & mask_q))));

    // R10: unqualified pins never raise status
    a_r10_unqualified_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(qual_w)) == '0));

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        logic [TBITS-1:0] code;
        assign code = cfg_w[TBITS*i +: TBITS];

        // R3
        a_r3_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (qual_w[i] && code == TRG_RISE && cur_w[i] && !prv_w[i]) |=> stat_q[i]);
        // R4
        a_r4_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (qual_w[i] && code == TRG_FALL && !cur_w[i] && prv_w[i]) |=> stat_q[i]);
        // R5 and R8: an active high level wins over a clear
        a_r5_high_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (qual_w[i] && code == TRG_HIGH && cur_w[i]) |=> stat_q[i]);
        // R6 and R8
        a_r6_low_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (qual_w[i] && code == TRG_LOW && !cur_w[i]) |=> stat_q[i]);
    end
endmodule

bind gpi_port gpi_chk u_chk (.*);

// File: tb/sim_gpi_port.sv
module sim_gpi_port;
    import gpi_pkg::*;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [AW-1:0]   wr_addr = '0;
    logic [DW-1:0]   wr_data = '0;
    logic [AW-1:0]   rd_addr = '0;
    logic [DW-1:0]   rd_data;
    logic [NPIN-1:0] pin_i = '0;
    logic            irq_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    gpi_port u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pin_i(pin_i), .irq_o(irq_o)
    );

    // ---------------- bench reference built from the requirements ----------
    logic [NPIN-1:0] m_s1, m_s2, m_pv, m_dir, m_use, m_mask, m_stat;
    logic [DW-1:0]   m_lo, m_hi;
    logic            m_irq;

    function automatic logic [NPIN-1:0] exp_ev(input logic [NPIN-1:0] c,
            input logic [NPIN-1:0] p, input logic [DW-1:0] lo,
            input logic [DW-1:0] hi, input logic [NPIN-1:0] q);
        logic [NPIN-1:0] e;
        for (int i = 0; i < NPIN; i++) begin
            logic [1:0] k;
            k = (i < 16) ? lo[2*i +: 2] : hi[2*(i-16) +: 2];
            case (k)
                2'b00:   e[i] = c[i] & ~p[i];
                2'b01:   e[i] = ~c[i] & p[i];
                2'b10:   e[i] = c[i];
                default: e[i] = ~c[i];
            endcase
            e[i] = e[i] & q[i];
        end
        return e;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_pv <= '0; m_dir <= '0; m_use <= '0;
            m_mask <= '0; m_stat <= '0; m_lo <= '0; m_hi <= '0; m_irq <= 1'b0;
        end else begin
            logic [NPIN-1:0] clr;
            clr = (wr_en && wr_addr == A_STAT) ? wr_data : '0;
            m_s1 <= pin_i; m_s2 <= m_s1; m_pv <= m_s2;
            if (wr_en && wr_addr == A_DIR)   m_dir  <= wr_data;
            if (wr_en && wr_addr == A_USE)   m_use  <= wr_data;
            if (wr_en && wr_addr == A_TRGLO) m_lo   <= wr_data;
            if (wr_en && wr_addr == A_TRGHI) m_hi   <= wr_data;
            if (wr_en && wr_addr == A_MASK)  m_mask <= wr_data;
            m_stat <= (m_stat & ~clr) | exp_ev(m_s2, m_pv, m_lo, m_hi, m_use & ~m_dir);
            m_irq  <= |(m_stat & m_mask);
        end
    end

    // ---------------- helpers ----------------------------------------------
    task automatic check(input bit ok, input string req,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_bit(input int b, input logic e, input string req);
        logic [DW-1:0] v;
        rd(A_STAT, v);
        check(v[b] == e, req, DW'(v[b]), DW'(e));
    endtask

    // ---------------- watchdog ---------------------------------------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    // ---------------- stimulus ---------------------------------------------
    initial begin
        logic [DW-1:0] v;
        void'($urandom(32'd4242));
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(AW'(a), v);
            check(v == '0, "R1 register zero", v, '0);
        end
        check(irq_o == 1'b0, "R1 irq low", DW'(irq_o), '0);

        // Settle pins 20 and 31 high before they are qualified
        pin_i[20] = 1'b1; pin_i[31] = 1'b1;
        cyc(4);
        // R2 / R11 configuration: pin7 output, pin8 unused
        wr(A_DIR, 32'h0000_0080);
        wr(A_USE, 32'hFFFF_FEFF);
        wr(A_TRGLO, 32'h0000_0800);   // pin5 code 10 at bits 11:10
        wr(A_TRGHI, 32'hC000_0100);   // pin20 code 01 at 9:8, pin31 code 11 at 31:30
        rd(A_DIR, v);   check(v == 32'h0000_0080, "R2 dir readback", v, 32'h0000_0080);
        rd(A_USE, v);   check(v == 32'hFFFF_FEFF, "R2 use readback", v, 32'hFFFF_FEFF);
        rd(A_TRGLO, v); check(v == 32'h0000_0800, "R2 trig low readback", v, 32'h0000_0800);
        rd(A_TRGHI, v); check(v == 32'hC000_0100, "R2 trig high readback", v, 32'hC000_0100);
        cyc(2);
        rd(A_STAT, v);  check(v == '0, "R11 no event from settled pins", v, '0);

        // R3 rising edge on pin3 and its latency
        pin_i[3] = 1'b1;
        cyc(2); chk_bit(3, 1'b0, "R3 not yet after two edges");
        cyc(1); chk_bit(3, 1'b1, "R3 rise latched");

        // R7 zero write keeps
        wr(A_STAT, 32'h0);
        chk_bit(3, 1'b1, "R7 zero write no effect");

        // R9 masking and registered output
        check(irq_o == 1'b0, "R9 masked irq low", DW'(irq_o), '0);
        wr(A_MASK, 32'h0000_0008);
        check(irq_o == 1'b0, "R9 irq one cycle after mask", DW'(irq_o), '0);
        cyc(1);
        check(irq_o == 1'b1, "R9 irq raised", DW'(irq_o), 32'h1);
        wr(A_STAT, 32'h0000_0008);
        chk_bit(3, 1'b0, "R7 write one clears");
        check(irq_o == 1'b1, "R9 irq lags clear", DW'(irq_o), 32'h1);
        cyc(1);
        check(irq_o == 1'b0, "R9 irq dropped", DW'(irq_o), '0);

        // R4 falling edge on pin20
        pin_i[20] = 1'b0;
        cyc(2); chk_bit(20, 1'b0, "R4 not yet");
        cyc(1); chk_bit(20, 1'b1, "R4 fall latched");
        wr(A_STAT, 32'h0010_0000);
        chk_bit(20, 1'b0, "R4 cleared, no new edge");

        // R5 / R8 high level on pin5
        pin_i[5] = 1'b1;
        cyc(3); chk_bit(5, 1'b1, "R5 high level sets");
        wr(A_STAT, 32'h0000_0020);
        chk_bit(5, 1'b1, "R8 level beats clear");
        pin_i[5] = 1'b0;
        cyc(4);
        wr(A_STAT, 32'h0000_0020);
        chk_bit(5, 1'b0, "R5 clear sticks after level ends");

        // R6 low level on pin31
        pin_i[31] = 1'b0;
        cyc(3); chk_bit(31, 1'b1, "R6 low level sets");
        wr(A_STAT, 32'h8000_0000);
        chk_bit(31, 1'b1, "R6 low level re-sets");
        pin_i[31] = 1'b1;
        cyc(4);
        wr(A_STAT, 32'h8000_0000);
        chk_bit(31, 1'b0, "R6 clear sticks after level ends");

        // R10 unqualified pins
        pin_i[7] = 1'b1; pin_i[8] = 1'b1;
        cyc(5);
        chk_bit(7, 1'b0, "R10 output-direction pin quiet");
        chk_bit(8, 1'b0, "R10 unused pin quiet");

        // Random phase against the bench reference
        rd_addr = A_STAT;
        for (int t = 0; t < 4000; t++) begin
            @(negedge clk);
            check(rd_data == m_stat, "R8 status vs reference", rd_data, m_stat);
            check(irq_o == m_irq, "R9 irq vs reference", DW'(irq_o), DW'(m_irq));
            pin_i = pin_i ^ ($urandom & $urandom & $urandom);
            wr_en = 1'b0;
            case ($urandom % 8)
                0: begin wr_en = 1'b1; wr_addr = AW'(A_TRGLO + ($urandom % 2)); wr_data = $urandom; end
                1: begin wr_en = 1'b1; wr_addr = A_MASK; wr_data = $urandom; end
                2: begin wr_en = 1'b1; wr_addr = AW'($urandom % 2); wr_data = $urandom & $urandom; end
                3, 4: begin wr_en = 1'b1; wr_addr = A_STAT; wr_data = $urandom; end
                default: ;
            endcase
        end
        @(negedge clk);
        wr_en = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule